// File: doc/BRIEF.md
# Non-normalized floating-point multiplier

This block multiplies two 32-bit floating-point words in a relaxed format that does not require normalization. Each word holds a sign in bit 31, an 8-bit biased exponent in bits 30:23 and a 23-bit significand in bits 22:0. The significand is fully explicit. Bit 22 has weight one and the lower bits are binary fractions, so an operand may carry leading zeros. Zero and tiny values get no special treatment, there are no special encodings and no flags are raised.

The two significands go through one full-width multiply, the biased exponents are added, and the bias is removed once. A build-time policy then picks which product bits form the result. The base policy always assumes the product has overflowed its integer bit. The overflow policy tests the top product bit. Two normalizing policies shift the product left by an amount predicted from the leading zeros of the inputs: one caps the shift at X positions, the other moves only in steps of X. The result is truncated. An optional half-unit-biased (HUB) mode gives round-to-nearest while still truncating. The result is registered once. The reset is asynchronous on assertion and released through a two-stage synchronizer.

Top module: `nnfp_mul`

## Requirements
- R1: The sign of the result, bit 31 of q, is the XOR of the sign bits of a and b.
- R2: With the base policy, the result significand is bits 45:23 of the 46-bit product of the two 23-bit significands, and the exponent is always raised by one.
- R3: With the overflow policy, when product bit 45 is set the result follows R2. When bit 45 is clear, bits 44:22 are taken and the exponent is not raised.
- R4: With the limited policy, each input significand's leading zeros are counted, with an all-zero field counting 23. The product is shifted left by the smaller of the summed count and X. Bits 45:23 are taken, and the exponent is raised by one and lowered by the shift.
- R5: With the radix policy, the shift is the largest multiple of X that does not exceed the summed leading-zero count. Otherwise the rules of R4 apply.
- R6: In HUB mode, each operand significand is extended by a 1 below its LSB to form a 24-bit operand. The 48-bit product uses the same window rules, measured from its bit 47, and the field is truncated.
- R7: The result exponent is ea + eb − 127 + (1 if raised) − shift. Product bits below the window are dropped without rounding.
- R8: If the computed exponent is negative, bits 30:0 of q are zero and the sign is kept. An exponent of exactly 0 is an ordinary result.
- R9: If the computed exponent exceeds 255, bits 30:0 of q are all ones and the sign is kept.
- R10: A zero significand is not a special case. It flows through the same multiply, exponent and clamp rules as any other value.
- R11: While rst_n is low, q is zero. After release and two synchronizer clocks, q shows, one clock later, the result for the a and b sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a | input | 32 | First operand word |
| b | input | 32 | Second operand word |
| q | output | 32 | Registered product word |

## Verification
Normalization and exponent clamping can act on the same product. A shift predicted from leading zeros lowers the exponent, and that can push a result that was otherwise in range below zero or hold it exactly at zero. The bench provokes this with operands that carry many leading zeros and small exponents. It also places exponent sums right at the clamp edges, at 0, 255 and 256. Every policy, HUB included, runs on the same stimulus in parallel, and each output is compared on every clock with a behavioural integer model of the requirements.

// File: rtl/nnfp_pkg.sv
package nnfp_pkg;
  // Result-bit selection policy
  typedef enum logic [1:0] {
    NRM_NONE  = 2'd0,  // overflow always assumed
    NRM_OVF   = 2'd1,  // top product bit tested
    NRM_LIMIT = 2'd2,  // shift capped at NORM_X
    NRM_RADIX = 2'd3   // shift in multiples of NORM_X
  } nrm_mode_e;
endpackage

// File: rtl/nnfp_lzc.sv
module nnfp_lzc #(
  parameter int W  = 23,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  // Lowest set bit is visited first, so the highest set bit decides.
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/nnfp_shift_pol.sv
module nnfp_shift_pol
  import nnfp_pkg::*;
#(
  parameter nrm_mode_e MODE   = NRM_LIMIT,
  parameter int        NORM_X = 4,
  parameter int        SW     = 6
) (
  input  logic [SW-1:0] lz_sum,
  output logic [SW-1:0] shamt
);
  localparam logic [SW-1:0] STEP = SW'(NORM_X);

  logic [SW-1:0] lim_sh;
  logic [SW-1:0] rad_sh;

  always_comb begin
    lim_sh = (lz_sum < STEP) ? lz_sum : STEP;
    rad_sh = (lz_sum / STEP) * STEP;
    case (MODE)
      NRM_LIMIT: shamt = lim_sh;
      NRM_RADIX: shamt = rad_sh;
      default:   shamt = '0;
    endcase
  end
endmodule

// File: rtl/nnfp_exp_pack.sv
module nnfp_exp_pack #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int BIAS  = 127,
  parameter int SW    = 6
) (
  input  logic               sgn,
  input  logic [EXP_W-1:0]   ex,
  input  logic [EXP_W-1:0]   ey,
  input  logic               adj,
  input  logic [SW-1:0]      shamt,
  input  logic [MAN_W-1:0]   sig,
  output logic [EXP_W+MAN_W:0] word
);
  // Wide enough that the true exponent never wraps; MSB is the sign.
  localparam int             EW      = EXP_W + SW + 2;
  localparam logic [EW-1:0]  EXP_TOP = EW'((1 << EXP_W) - 1);

  logic [EW-1:0] e_u;
  logic          under;
  logic          over;

  always_comb begin
    e_u   = EW'(ex) + EW'(ey) - EW'(BIAS) + EW'(adj) - EW'(shamt);
    under = e_u[EW-1];
    over  = !under && (e_u > EXP_TOP);
    if (under)
      word = {sgn, {(EXP_W + MAN_W){1'b0}}};
    else if (over)
      word = {sgn, {(EXP_W + MAN_W){1'b1}}};
    else
      word = {sgn, e_u[EXP_W-1:0], sig};
  end
endmodule

// File: rtl/nnfp_mul.sv
module nnfp_mul
  import nnfp_pkg::*;
#(
  parameter int        EXP_W  = 8,
  parameter int        MAN_W  = 23,
  parameter int        BIAS   = 127,
  parameter nrm_mode_e MODE   = NRM_LIMIT,
  parameter int        NORM_X = 4,
  parameter bit        HUB    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EXP_W+MAN_W:0] a,
  input  logic [EXP_W+MAN_W:0] b,
  output logic [EXP_W+MAN_W:0] q
);
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int OPW    = MAN_W + (HUB ? 1 : 0);
  localparam int PW     = 2 * OPW;
  localparam int CW     = $clog2(MAN_W + 1);
  localparam int SW     = CW + 1;
  localparam int LO_W   = PW - MAN_W;
  localparam int TAIL_W = PW - 1 - MAN_W;

  // Field split
  logic               sgn;
  logic [EXP_W-1:0]   ex, ey;
  logic [MAN_W-1:0]   mx, my;

  assign sgn = a[WORD_W-1] ^ b[WORD_W-1];
  assign ex  = a[WORD_W-2 -: EXP_W];
  assign ey  = b[WORD_W-2 -: EXP_W];
  assign mx  = a[MAN_W-1:0];
  assign my  = b[MAN_W-1:0];

  // Operand forming: HUB appends the implicit half-ulp one
  logic [OPW-1:0] opx, opy;
  generate
    if (HUB) begin : g_hub
      assign opx = {mx, 1'b1};
      assign opy = {my, 1'b1};
    end else begin : g_trunc
      assign opx = mx;
      assign opy = my;
    end
  endgenerate

  logic [PW-1:0] prod;
  assign prod = PW'(opx) * PW'(opy);

  // Leading zeros predicted from the inputs
  logic [CW-1:0] lz_x, lz_y;
  logic [SW-1:0] lz_sum, shamt;

  nnfp_lzc #(.W(MAN_W), .CW(CW)) u_lzc_x (.vec(mx), .cnt(lz_x));
  nnfp_lzc #(.W(MAN_W), .CW(CW)) u_lzc_y (.vec(my), .cnt(lz_y));

  assign lz_sum = SW'(lz_x) + SW'(lz_y);

  nnfp_shift_pol #(.MODE(MODE), .NORM_X(NORM_X), .SW(SW)) u_pol (
    .lz_sum (lz_sum),
    .shamt  (shamt)
  );

  // Window selection
  logic [PW-1:0]     shifted;
  logic [MAN_W-1:0]  win_hi, win_lo;
  logic [LO_W-1:0]   unused_hi_rest;
  logic [TAIL_W-1:0] unused_lo_rest;
  logic              carry;
  logic [MAN_W-1:0]  sig;
  logic              adj;

  assign shifted = prod << shamt;
  assign {win_hi, unused_hi_rest}        = shifted;
  assign {carry, win_lo, unused_lo_rest} = prod;

  always_comb begin
    if (MODE == NRM_OVF && !carry) begin
      sig = win_lo;
      adj = 1'b0;
    end else begin
      sig = win_hi;
      adj = 1'b1;
    end
  end

  logic [WORD_W-1:0] q_next;

  nnfp_exp_pack #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS), .SW(SW)) u_pack (
    .sgn   (sgn),
    .ex    (ex),
    .ey    (ey),
    .adj   (adj),
    .shamt (shamt),
    .sig   (sig),
    .word  (q_next)
  );

  // Reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) q <= '0;
    else             q <= q_next;
  end
endmodule

// File: rtl/nnfp_mul_chk.sv
module nnfp_mul_chk
  import nnfp_pkg::*;
#(
  parameter int        EXP_W  = 8,
  parameter int        MAN_W  = 23,
  parameter int        BIAS   = 127,
  parameter nrm_mode_e MODE   = NRM_LIMIT,
  parameter int        NORM_X = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_ok,
  input logic [EXP_W+MAN_W:0] a,
  input logic [EXP_W+MAN_W:0] b,
  input logic [EXP_W+MAN_W:0] q
);
  localparam int WORD_W  = 1 + EXP_W + MAN_W;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  logic [EXP_W:0] esum;
  int             e_nom;
  int             q_exp;

  assign esum  = {1'b0, a[WORD_W-2 -: EXP_W]} + {1'b0, b[WORD_W-2 -: EXP_W]};
  assign e_nom = int'(esum) - BIAS + 1;
  assign q_exp = int'(q[WORD_W-2 -: EXP_W]);

  // R11
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_clear_chk: assert (q == '0);
    end
  end

  // R1
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(rst_ok) |-> q[WORD_W-1] == ($past(a[WORD_W-1]) ^ $past(b[WORD_W-1])));

  // R8
  under_clamp_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(e_nom) < 0) |-> q[WORD_W-2:0] == '0);

  generate
    if (MODE == NRM_NONE || MODE == NRM_OVF) begin : g_sat
      // R9
      sat_max_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        ($past(rst_ok) && $past(e_nom) > EXP_MAX + 1) |-> q[WORD_W-2:0] == '1);
    end
    if (MODE == NRM_NONE) begin : g_base
      // R2
      base_exp_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        ($past(rst_ok) && $past(e_nom) >= 0 && $past(e_nom) <= EXP_MAX)
        |-> q_exp == $past(e_nom));
    end
    if (MODE == NRM_LIMIT) begin : g_lim
      // R4
      lim_shift_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        ($past(rst_ok) && $past(e_nom) >= NORM_X && $past(e_nom) <= EXP_MAX)
        |-> (q_exp <= $past(e_nom) && q_exp >= $past(e_nom) - NORM_X));
    end
    if (MODE == NRM_RADIX) begin : g_rad
      // R5
      rad_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
        ($past(rst_ok) && $past(e_nom) >= 2 * MAN_W && $past(e_nom) <= EXP_MAX)
        |-> (q_exp <= $past(e_nom) && (($past(e_nom) - q_exp) % NORM_X) == 0));
    end
  endgenerate
endmodule

bind nnfp_mul nnfp_mul_chk #(
  .EXP_W (EXP_W),
  .MAN_W (MAN_W),
  .BIAS  (BIAS),
  .MODE  (MODE),
  .NORM_X(NORM_X)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rst_ok (rst_sync_n),
  .a      (a),
  .b      (b),
  .q      (q)
);

// File: tb/nnfp_mul_tb.sv
`timescale 1ns/1ps
module nnfp_mul_tb;
  import nnfp_pkg::*;

  localparam int NI = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [31:0] q_arr [NI];

  always #2 clk = ~clk;

  nnfp_mul #(.MODE(NRM_LIMIT), .NORM_X(4), .HUB(1'b0)) u_dut
    (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .q(q_arr[0]));
  nnfp_mul #(.MODE(NRM_NONE),  .NORM_X(1), .HUB(1'b0)) u_base
    (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .q(q_arr[1]));
  nnfp_mul #(.MODE(NRM_OVF),   .NORM_X(1), .HUB(1'b0)) u_ovf
    (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .q(q_arr[2]));
  nnfp_mul #(.MODE(NRM_RADIX), .NORM_X(8), .HUB(1'b0)) u_rad
    (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .q(q_arr[3]));
  nnfp_mul #(.MODE(NRM_LIMIT), .NORM_X(6), .HUB(1'b1)) u_hub
    (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .q(q_arr[4]));

  nrm_mode_e modes [NI] = '{NRM_LIMIT, NRM_NONE, NRM_OVF, NRM_RADIX, NRM_LIMIT};
  int        xs    [NI] = '{4, 1, 1, 8, 6};
  bit        hubs  [NI] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  string     itag  [NI] = '{"R4", "R2", "R3", "R5", "R6"};

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // Behavioural reference of the requirements
  function automatic logic [31:0] ref_mul(input logic [31:0] va, input logic [31:0] vb,
                                          input nrm_mode_e md, input int nx, input bit hb);
    longint unsigned pa, pb, p;
    int pw, lza, lzb, lz, sh, adj, e;
    logic [22:0] sig;
    logic sg;
    sg = va[31] ^ vb[31];
    pa = longint'(va[22:0]);
    pb = longint'(vb[22:0]);
    if (hb) begin
      pa = pa * 2 + 1;
      pb = pb * 2 + 1;
      pw = 48;
    end else begin
      pw = 46;
    end
    p = pa * pb;
    lza = 23;
    lzb = 23;
    for (int i = 0; i < 23; i++) begin
      if (va[i]) lza = 22 - i;
      if (vb[i]) lzb = 22 - i;
    end
    lz  = lza + lzb;
    sh  = 0;
    adj = 1;
    case (md)
      NRM_OVF:   if (p[pw-1] == 1'b0) adj = 0;
      NRM_LIMIT: sh = (lz < nx) ? lz : nx;
      NRM_RADIX: sh = (lz / nx) * nx;
      default:   sh = 0;
    endcase
    p = p << sh;
    if (adj != 0) sig = 23'(p >> (pw - 23));
    else          sig = 23'(p >> (pw - 24));
    e = int'(va[30:23]) + int'(vb[30:23]) - 127 + adj - sh;
    if (e < 0)        return {sg, 31'h0};
    else if (e > 255) return {sg, 31'h7FFFFFFF};
    else              return {sg, 8'(e), sig};
  endfunction

  bit          pend = 1'b0;
  logic [31:0] expv [NI];
  logic [31:0] pa_s, pb_s;
  string       ptag;

  // Compare previous cycle's expectations, then apply new operands
  task automatic step(input logic [31:0] va, input logic [31:0] vb, input string tag);
    @(negedge clk);
    if (pend) begin
      for (int i = 0; i < NI; i++) begin
        checks++;
        if (q_arr[i] !== expv[i]) begin
          errors++;
          $display("FAIL %s/%s inst%0d a=%h b=%h got %h expected %h",
                   ptag, itag[i], i, pa_s, pb_s, q_arr[i], expv[i]);
        end
      end
    end
    a = va;
    b = vb;
    for (int i = 0; i < NI; i++) expv[i] = ref_mul(va, vb, modes[i], xs[i], hubs[i]);
    pa_s = va;
    pb_s = vb;
    ptag = tag;
    pend = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11: output cleared during reset
    for (int i = 0; i < NI; i++) begin
      checks++;
      if (q_arr[i] !== 32'h0) begin
        errors++;
        $display("FAIL R11 inst%0d reset got %h expected %h", i, q_arr[i], 32'h0);
      end
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    step(32'h3FC00000, 32'h3FC00000, "R7");   // 1.0 x 1.0
    step(32'hBFC00000, 32'h3FC00000, "R1");   // sign mix
    step(32'hBFC00000, 32'hBFC00000, "R1");
    step(32'h3FFFFFFF, 32'h3FFFFFFF, "R3");   // product overflows
    step(32'h3F800001, 32'h3FC00000, "R3");   // no overflow
    step(32'h46000ABC, 32'h46003FFF, "R4");   // many leading zeros
    step(32'h46000001, 32'h46001234, "R5");
    step(32'h0A400000, 32'h0A400000, "R8");   // exponent underflow
    step(32'h1FC00000, 32'h1FC00000, "R8");   // exponent exactly 0
    step(32'h20000100, 32'h20400000, "R8");   // shift drives exponent negative
    step(32'h7D400000, 32'h7D400000, "R9");   // saturate
    step(32'h5F400000, 32'h5FC00000, "R9");   // exponent 255
    step(32'h5FC00000, 32'h5FC00000, "R9");   // exponent 256
    step(32'h3F800000, 32'h3FC00000, "R10");  // zero significand
    step(32'h3F800000, 32'h3F800000, "R10");
    step(32'hC6000000, 32'h46400000, "R10");

    for (int k = 0; k < 600; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom();
      rb = $urandom();
      if (k % 2 == 0) begin
        ra[30:23] = 8'(90 + ($urandom() % 80));
        rb[30:23] = 8'(90 + ($urandom() % 80));
      end
      ra[22:0] = ra[22:0] >> ($urandom() % 16);
      rb[22:0] = rb[22:0] >> ($urandom() % 16);
      step(ra, rb, "R7");
    end

    step(32'h0, 32'h0, "R10");
    step(32'h0, 32'h0, "R10");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule